// File: doc/BRIEF.md
# Multi-Level Prioritized Interrupt Controller

The controller gathers a vector of level-sensitive maskable interrupt requests, one high-priority request gated by its own mask bit, and six non-maskable exception sources. It chooses a winner for each of two consumers: the main CPU and a coprocessor. Each maskable request holds a 3-bit priority level, where 0 disables it and 1 to 7 rank it, and a route bit that sends it to the CPU (0) or to the coprocessor (1). On an acknowledge, the winner's vector is latched. The vector is a programmable base plus twice the winner's slot number. Slots 0 to N_REQ-1 are the maskable requests, slot N_REQ is the mask-gated high-priority request, slots N_REQ+1 to N_REQ+6 are the non-maskable sources, and slot N_REQ+7 is the spurious vector.

On the CPU side a current-level register rises to the level of each accepted request, and the previous level is pushed onto a 7-entry stack. A return strobe pops the stack. A handler can therefore be preempted only by a strictly higher level, to any depth the stack allows. On the coprocessor side a thread may be interrupted once, and only by a strictly higher level. A second nesting level is never granted.

Top module: `irq_prio_ctl`

## Requirements
- R1: After reset, cpu_req_o and cop_req_o are 0, cpu_lvl_o is 0, cop_depth_o is 0, both vectors are 0, every level is 0, every route is CPU and the base is 0.
- R2: A request whose configured level is 0 never raises cpu_req_o or cop_req_o.
- R3: A CPU-routed maskable request with a level above cpu_lvl_o raises cpu_req_o in the same cycle when cpu_imask_i is 0. The cycle after cpu_ack_i, cpu_vec_o equals base + 2*index, and it holds until the next acknowledge.
- R4: Among eligible maskable requests the highest level wins, and a tie goes to the lower index.
- R5: After an accepted acknowledge of a maskable request, cpu_lvl_o equals that request's level. Requests at or below cpu_lvl_o are blocked, and a strictly higher one raises cpu_req_o.
- R6: cpu_rti_i without cpu_ack_i restores the level saved by the matching acknowledge. With nothing saved, it leaves cpu_lvl_o unchanged.
- R7: cpu_imask_i = 1 blocks CPU-routed maskable requests only. Coprocessor-routed requests are unaffected.
- R8: Any set bit of nmi_i requests the CPU regardless of masks and level, and it outranks all other sources. The lowest set bit j wins with slot N_REQ+1+j, and acceptance sets cpu_lvl_o to 7.
- R9: xirq_i with cpu_xmask_i = 0 requests the CPU regardless of cpu_imask_i and level. It outranks maskable requests, uses slot N_REQ, and sets cpu_lvl_o to 7. cpu_xmask_i = 1 blocks it.
- R10: An acknowledge while the matching req output is 0 latches the spurious vector base + 2*(N_REQ+7) and changes neither cpu_lvl_o nor cop_depth_o.
- R11: Coprocessor-routed requests raise cop_req_o and never cpu_req_o. An accepted cop_ack_i increments cop_depth_o and latches base + 2*index on cop_vec_o.
- R12: At depth 0 any enabled coprocessor request is granted. At depth 1 only a level strictly above the running one is granted. At depth 2 none is granted. cop_done_i lowers the depth by one, and at depth 0 it does nothing.
- R13: While 7 CPU levels are saved, cpu_req_o stays 0, even with nmi_i set.
- R14: cfg_we_i writes cfg_lvl_i and cfg_cop_i into request cfg_idx_i. cfg_base_we_i loads the base. Both take effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | N_REQ | Maskable requests, level sensitive |
| xirq_i | input | 1 | High-priority request gated by cpu_xmask_i |
| nmi_i | input | 6 | Non-maskable sources: bad opcode, software, system call, three access violations |
| cpu_imask_i | input | 1 | CPU mask for maskable requests |
| cpu_xmask_i | input | 1 | CPU mask for xirq_i |
| cfg_we_i | input | 1 | Write level and route of one request |
| cfg_idx_i | input | IDX_W | Request index to configure |
| cfg_lvl_i | input | 3 | Level to write, 0 disables |
| cfg_cop_i | input | 1 | Route to write, 1 selects the coprocessor |
| cfg_base_we_i | input | 1 | Load vector base |
| cfg_base_i | input | VEC_W | Vector base value |
| cpu_req_o | output | 1 | CPU has a pending winner |
| cpu_ack_i | input | 1 | CPU acknowledge |
| cpu_rti_i | input | 1 | CPU return from handler |
| cpu_vec_o | output | VEC_W | Latched CPU vector |
| cpu_lvl_o | output | 3 | Current CPU level |
| cop_req_o | output | 1 | Coprocessor has a pending winner |
| cop_ack_i | input | 1 | Coprocessor acknowledge |
| cop_done_i | input | 1 | Coprocessor thread finished |
| cop_vec_o | output | VEC_W | Latched coprocessor vector |
| cop_depth_o | output | 2 | Coprocessor nesting depth |

## Verification
The assertions assume that cpu_ack_i and cpu_rti_i both refer to handlers this block granted, and that a non-maskable source is cleared once its handler is entered. Without that, repeated exception acknowledges would fill the level stack. The stimulus keeps non-maskable sources rare and short, and the stack-full gate of R13 bounds the rest. Return strobes on an empty stack are allowed on purpose, because R6 defines them as harmless.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;
  localparam int unsigned LVL_W   = 3;
  localparam int unsigned LVL_TOP = 7;
  localparam int unsigned NMI_N   = 6;
  typedef logic [LVL_W-1:0] lvl_t;
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_ctl_pkg::*;
#(
  parameter int unsigned N_REQ = 16,
  parameter int unsigned VEC_W = 16,
  parameter logic [VEC_W-1:0] BASE_RST = '0,
  localparam int unsigned IDX_W = $clog2(N_REQ)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] idx_i,
  input  lvl_t             lvl_i,
  input  logic             cop_i,
  input  logic             base_we_i,
  input  logic [VEC_W-1:0] base_i,
  output lvl_t [N_REQ-1:0] lvl_o,
  output logic [N_REQ-1:0] cop_o,
  output logic [VEC_W-1:0] base_o
);
  lvl_t [N_REQ-1:0] lvl_q;
  logic [N_REQ-1:0] cop_q;
  logic [VEC_W-1:0] base_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q  <= '0;
      cop_q  <= '0;
      base_q <= BASE_RST;
    end else begin
      if (we_i) begin
        lvl_q[idx_i] <= lvl_i;
        cop_q[idx_i] <= cop_i;
      end
      if (base_we_i) base_q <= base_i;
    end
  end

  assign lvl_o  = lvl_q;
  assign cop_o  = cop_q;
  assign base_o = base_q;
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
  import irq_ctl_pkg::*;
#(
  parameter int unsigned N_REQ = 16,
  localparam int unsigned IDX_W = $clog2(N_REQ)
) (
  input  logic [N_REQ-1:0] req_i,
  input  lvl_t [N_REQ-1:0] lvl_i,
  input  lvl_t             thr_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o,
  output lvl_t             lvl_o
);
  // scan downward with >= so equal levels settle on the lower index
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    lvl_o   = '0;
    for (int i = N_REQ - 1; i >= 0; i--) begin
      if (req_i[i] && (lvl_i[i] > thr_i) && (lvl_i[i] >= lvl_o)) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
        lvl_o   = lvl_i[i];
      end
    end
  end
endmodule

// File: rtl/irq_lvl_stack.sv
module irq_lvl_stack
  import irq_ctl_pkg::*;
#(
  parameter int unsigned DEPTH = 7,
  localparam int unsigned PTR_W = $clog2(DEPTH + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic push_i,
  input  logic pop_i,
  input  lvl_t din_i,
  output lvl_t dout_o,
  output logic empty_o,
  output logic full_o
);
  lvl_t [DEPTH-1:0] mem_q;
  logic [PTR_W-1:0] ptr_q;
  logic [PTR_W-1:0] top_idx;

  assign top_idx = (ptr_q == '0) ? '0 : ptr_q - 1'b1;
  assign dout_o  = mem_q[top_idx];
  assign empty_o = (ptr_q == '0);
  assign full_o  = (ptr_q == PTR_W'(DEPTH));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q <= '0;
      ptr_q <= '0;
    end else if (push_i && !full_o) begin
      mem_q[ptr_q] <= din_i;
      ptr_q        <= ptr_q + 1'b1;
    end else if (pop_i && !empty_o) begin
      ptr_q <= ptr_q - 1'b1;
    end
  end
endmodule

// File: rtl/irq_prio_ctl.sv
module irq_prio_ctl
  import irq_ctl_pkg::*;
#(
  parameter int unsigned N_REQ = 16,
  parameter int unsigned VEC_W = 16,
  parameter int unsigned STK_D = 7,
  parameter logic [VEC_W-1:0] BASE_RST = '0,
  localparam int unsigned IDX_W = $clog2(N_REQ)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_REQ-1:0] irq_i,
  input  logic             xirq_i,
  input  logic [NMI_N-1:0] nmi_i,
  input  logic             cpu_imask_i,
  input  logic             cpu_xmask_i,
  input  logic             cfg_we_i,
  input  logic [IDX_W-1:0] cfg_idx_i,
  input  logic [LVL_W-1:0] cfg_lvl_i,
  input  logic             cfg_cop_i,
  input  logic             cfg_base_we_i,
  input  logic [VEC_W-1:0] cfg_base_i,
  output logic             cpu_req_o,
  input  logic             cpu_ack_i,
  input  logic             cpu_rti_i,
  output logic [VEC_W-1:0] cpu_vec_o,
  output logic [LVL_W-1:0] cpu_lvl_o,
  output logic             cop_req_o,
  input  logic             cop_ack_i,
  input  logic             cop_done_i,
  output logic [VEC_W-1:0] cop_vec_o,
  output logic [1:0]       cop_depth_o
);
  localparam int unsigned SLOT_W    = $clog2(N_REQ + NMI_N + 2);
  localparam int unsigned SLOT_X    = N_REQ;
  localparam int unsigned SLOT_NMI  = N_REQ + 1;
  localparam int unsigned SLOT_SPUR = N_REQ + NMI_N + 1;

  lvl_t [N_REQ-1:0] cfg_lvl;
  logic [N_REQ-1:0] cfg_cop;
  logic [VEC_W-1:0] base;

  irq_cfg_regs #(.N_REQ(N_REQ), .VEC_W(VEC_W), .BASE_RST(BASE_RST)) u_cfg (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .idx_i(cfg_idx_i), .lvl_i(cfg_lvl_i), .cop_i(cfg_cop_i),
    .base_we_i(cfg_base_we_i), .base_i(cfg_base_i),
    .lvl_o(cfg_lvl), .cop_o(cfg_cop), .base_o(base)
  );

  // ---------------- CPU side ----------------
  lvl_t             cpu_lvl_q;
  logic [VEC_W-1:0] cpu_vec_q;
  logic             cpu_found;
  logic [IDX_W-1:0] cpu_idx;
  lvl_t             cpu_win_lvl;
  logic             cpu_req;
  logic [SLOT_W-1:0] cpu_slot;
  lvl_t             cpu_new_lvl;
  logic             stk_full, stk_empty;
  lvl_t             stk_top;
  logic [2:0]       nmi_j;
  logic             stk_push, stk_pop;

  irq_prio_pick #(.N_REQ(N_REQ)) u_cpu_pick (
    .req_i(irq_i & ~cfg_cop & {N_REQ{~cpu_imask_i}}),
    .lvl_i(cfg_lvl), .thr_i(cpu_lvl_q),
    .found_o(cpu_found), .idx_o(cpu_idx), .lvl_o(cpu_win_lvl)
  );

  always_comb begin
    nmi_j = '0;
    for (int j = NMI_N - 1; j >= 0; j--)
      if (nmi_i[j]) nmi_j = 3'(j);
  end

  always_comb begin
    cpu_req     = 1'b0;
    cpu_slot    = SLOT_W'(SLOT_SPUR);
    cpu_new_lvl = cpu_lvl_q;
    if (!stk_full) begin
      if (|nmi_i) begin
        cpu_req     = 1'b1;
        cpu_slot    = SLOT_W'(SLOT_NMI) + SLOT_W'(nmi_j);
        cpu_new_lvl = lvl_t'(LVL_TOP);
      end else if (xirq_i && !cpu_xmask_i) begin
        cpu_req     = 1'b1;
        cpu_slot    = SLOT_W'(SLOT_X);
        cpu_new_lvl = lvl_t'(LVL_TOP);
      end else if (cpu_found) begin
        cpu_req     = 1'b1;
        cpu_slot    = SLOT_W'(cpu_idx);
        cpu_new_lvl = cpu_win_lvl;
      end
    end
  end

  assign stk_push = cpu_ack_i && cpu_req;
  assign stk_pop  = cpu_rti_i && !cpu_ack_i && !stk_empty;

  irq_lvl_stack #(.DEPTH(STK_D)) u_stk (
    .clk_i, .rst_ni,
    .push_i(stk_push), .pop_i(stk_pop), .din_i(cpu_lvl_q),
    .dout_o(stk_top), .empty_o(stk_empty), .full_o(stk_full)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cpu_lvl_q <= '0;
      cpu_vec_q <= '0;
    end else if (cpu_ack_i) begin
      cpu_vec_q <= base + VEC_W'({cpu_slot, 1'b0});
      if (cpu_req) cpu_lvl_q <= cpu_new_lvl;
    end else if (stk_pop) begin
      cpu_lvl_q <= stk_top;
    end
  end

  // ---------------- coprocessor side ----------------
  logic [1:0]       cop_depth_q;
  lvl_t [1:0]       cop_lvl_q;
  logic [VEC_W-1:0] cop_vec_q;
  lvl_t             cop_thr;
  logic             cop_found;
  logic [IDX_W-1:0] cop_idx;
  lvl_t             cop_win_lvl;
  logic             cop_req;
  logic [SLOT_W-1:0] cop_slot;

  assign cop_thr = (cop_depth_q == 2'd0) ? '0 : cop_lvl_q[0];

  irq_prio_pick #(.N_REQ(N_REQ)) u_cop_pick (
    .req_i(irq_i & cfg_cop),
    .lvl_i(cfg_lvl), .thr_i(cop_thr),
    .found_o(cop_found), .idx_o(cop_idx), .lvl_o(cop_win_lvl)
  );

  assign cop_req  = cop_found && (cop_depth_q != 2'd2);
  assign cop_slot = cop_req ? SLOT_W'(cop_idx) : SLOT_W'(SLOT_SPUR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cop_depth_q <= '0;
      cop_lvl_q   <= '0;
      cop_vec_q   <= '0;
    end else if (cop_ack_i) begin
      cop_vec_q <= base + VEC_W'({cop_slot, 1'b0});
      if (cop_req) begin
        cop_lvl_q[cop_depth_q[0]] <= cop_win_lvl;
        cop_depth_q               <= cop_depth_q + 2'd1;
      end
    end else if (cop_done_i && cop_depth_q != 2'd0) begin
      cop_depth_q <= cop_depth_q - 2'd1;
    end
  end

  assign cpu_req_o   = cpu_req;
  assign cpu_vec_o   = cpu_vec_q;
  assign cpu_lvl_o   = cpu_lvl_q;
  assign cop_req_o   = cop_req;
  assign cop_vec_o   = cop_vec_q;
  assign cop_depth_o = cop_depth_q;
endmodule

// File: rtl/irq_prio_ctl_chk.sv
module irq_prio_ctl_chk
  import irq_ctl_pkg::*;
#(
  parameter int unsigned VEC_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [NMI_N-1:0] nmi_i,
  input logic             xirq_i,
  input logic             cpu_xmask_i,
  input logic             cpu_req_o,
  input logic             cpu_ack_i,
  input logic             cpu_rti_i,
  input logic [VEC_W-1:0] cpu_vec_o,
  input logic [LVL_W-1:0] cpu_lvl_o,
  input logic             cop_req_o,
  input logic             cop_ack_i,
  input logic             cop_done_i,
  input logic [1:0]       cop_depth_o,
  input logic             stk_full
);
  assert_vec_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cpu_ack_i |=> $stable(cpu_vec_o));

  assert_lvl_rises_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_ack_i && cpu_req_o && !(|nmi_i) && !(xirq_i && !cpu_xmask_i))
      |=> (cpu_lvl_o > $past(cpu_lvl_o)));

  assert_rti_no_rise_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_rti_i && !cpu_ack_i) |=> (cpu_lvl_o <= $past(cpu_lvl_o)));

  assert_nmi_req_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|nmi_i) && !stk_full) |-> cpu_req_o);

  assert_nmi_top_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_ack_i && cpu_req_o && (|nmi_i)) |=> (cpu_lvl_o == 3'd7));

  assert_spur_keeps_lvl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_ack_i && !cpu_req_o) |=> $stable(cpu_lvl_o));

  assert_cop_step_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cop_ack_i && cop_req_o) |=> (cop_depth_o == $past(cop_depth_o) + 2'd1));

  assert_cop_cap_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cop_depth_o <= 2'd2) && !(cop_req_o && cop_depth_o == 2'd2));

  assert_cop_done_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cop_done_i && !cop_ack_i && cop_depth_o != 2'd0)
      |=> (cop_depth_o == $past(cop_depth_o) - 2'd1));

  assert_full_gate_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(stk_full && cpu_req_o));
endmodule

bind irq_prio_ctl irq_prio_ctl_chk #(.VEC_W(VEC_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .nmi_i(nmi_i), .xirq_i(xirq_i),
  .cpu_xmask_i(cpu_xmask_i), .cpu_req_o(cpu_req_o), .cpu_ack_i(cpu_ack_i),
  .cpu_rti_i(cpu_rti_i), .cpu_vec_o(cpu_vec_o), .cpu_lvl_o(cpu_lvl_o),
  .cop_req_o(cop_req_o), .cop_ack_i(cop_ack_i), .cop_done_i(cop_done_i),
  .cop_depth_o(cop_depth_o), .stk_full(stk_full)
);

// File: tb/irq_prio_ctl_test.sv
`timescale 1ns/100ps
module irq_prio_ctl_test;
  localparam int N = 16;
  localparam int SPUR = N + 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [N-1:0] irq = '0;
  logic xirq = 0, imask = 0, xmask = 0;
  logic [5:0] nmi = '0;
  logic cfg_we = 0, cfg_cop = 0, base_we = 0;
  logic [3:0] cfg_idx = '0;
  logic [2:0] cfg_lvl = '0;
  logic [15:0] base_d = '0;
  logic ack = 0, rti = 0, cack = 0, cdone = 0;
  logic cpu_req, cop_req;
  logic [15:0] cpu_vec, cop_vec;
  logic [2:0] cpu_lvl;
  logic [1:0] cop_dep;

  irq_prio_ctl uut (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .xirq_i(xirq), .nmi_i(nmi),
    .cpu_imask_i(imask), .cpu_xmask_i(xmask),
    .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx), .cfg_lvl_i(cfg_lvl), .cfg_cop_i(cfg_cop),
    .cfg_base_we_i(base_we), .cfg_base_i(base_d),
    .cpu_req_o(cpu_req), .cpu_ack_i(ack), .cpu_rti_i(rti), .cpu_vec_o(cpu_vec),
    .cpu_lvl_o(cpu_lvl), .cop_req_o(cop_req), .cop_ack_i(cack), .cop_done_i(cdone),
    .cop_vec_o(cop_vec), .cop_depth_o(cop_dep)
  );

  int n_chk = 0, n_bad = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic eq(input string tag, input int act, input int exp);
    chk(act == exp, tag, act, exp);
  endtask

  // reference model
  int m_lvl[N];
  bit m_cop[N];
  logic [15:0] m_base, m_vec, m_cvec;
  int m_cur, m_cdep;
  int m_clvl[2];
  int m_stk[$];

  function automatic bit cpu_pick(output int slot, output int nl);
    slot = SPUR; nl = m_cur;
    if (m_stk.size() >= 7) return 0;
    for (int j = 0; j < 6; j++)
      if (nmi[j]) begin slot = N + 1 + j; nl = 7; return 1; end
    if (xirq && !xmask) begin slot = N; nl = 7; return 1; end
    if (imask) return 0;
    begin
      int bl = 0;
      for (int i = N - 1; i >= 0; i--)
        if (irq[i] && !m_cop[i] && m_lvl[i] > m_cur && m_lvl[i] >= bl) begin
          bl = m_lvl[i]; slot = i; nl = m_lvl[i];
        end
      return bl != 0;
    end
  endfunction

  function automatic bit cop_pick(output int slot, output int nl);
    int thr = (m_cdep == 0) ? 0 : m_clvl[0];
    int bl = 0;
    slot = SPUR; nl = 0;
    if (m_cdep >= 2) return 0;
    for (int i = N - 1; i >= 0; i--)
      if (irq[i] && m_cop[i] && m_lvl[i] > thr && m_lvl[i] >= bl) begin
        bl = m_lvl[i]; slot = i; nl = m_lvl[i];
      end
    return bl != 0;
  endfunction

  task automatic peek();
    #0.5;
  endtask

  // one clock: compare combinational outputs, advance model, compare registered outputs
  task automatic cyc();
    int cs, cl, ks, kl;
    bit cf, kf;
    #0.5;
    cf = cpu_pick(cs, cl);
    kf = cop_pick(ks, kl);
    eq("R3 cpu_req_o", int'(cpu_req), int'(cf));
    eq("R11 cop_req_o", int'(cop_req), int'(kf));
    if (ack) begin
      m_vec = m_base + 16'(2 * cs);
      if (cf) begin m_stk.push_back(m_cur); m_cur = cl; end
    end else if (rti && m_stk.size() > 0) begin
      m_cur = m_stk.pop_back();
    end
    if (cack) begin
      m_cvec = m_base + 16'(2 * ks);
      if (kf) begin m_clvl[m_cdep] = kl; m_cdep++; end
    end else if (cdone && m_cdep > 0) begin
      m_cdep--;
    end
    if (cfg_we) begin m_lvl[cfg_idx] = cfg_lvl; m_cop[cfg_idx] = cfg_cop; end
    if (base_we) m_base = base_d;
    @(posedge clk);
    @(negedge clk);
    eq("R5 cpu_lvl_o", int'(cpu_lvl), m_cur);
    eq("R3 cpu_vec_o", int'(cpu_vec), int'(m_vec));
    eq("R12 cop_depth_o", int'(cop_dep), m_cdep);
    eq("R11 cop_vec_o", int'(cop_vec), int'(m_cvec));
    ack = 0; rti = 0; cack = 0; cdone = 0; cfg_we = 0; base_we = 0;
  endtask

  task automatic cfg(input int idx, input int lvl, input bit cop);
    cfg_we = 1; cfg_idx = 4'(idx); cfg_lvl = 3'(lvl); cfg_cop = cop;
    cyc();
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < N; i++) begin m_lvl[i] = 0; m_cop[i] = 0; end
    m_base = 0; m_vec = 0; m_cvec = 0; m_cur = 0; m_cdep = 0; m_clvl = '{0, 0};
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    eq("R1 cpu_req_o", int'(cpu_req), 0);
    eq("R1 cop_req_o", int'(cop_req), 0);
    eq("R1 cpu_lvl_o", int'(cpu_lvl), 0);
    eq("R1 cop_depth_o", int'(cop_dep), 0);
    eq("R1 cpu_vec_o", int'(cpu_vec), 0);

    // R14 configuration
    base_we = 1; base_d = 16'h1000;
    cfg(2, 3, 0); cfg(5, 3, 0); cfg(9, 6, 0); cfg(12, 2, 1); cfg(13, 5, 1);

    // R2 level 0 is disabled
    irq = 16'h0001; peek();
    eq("R2 cpu_req_o", int'(cpu_req), 0);
    eq("R2 cop_req_o", int'(cop_req), 0);
    cyc();

    // R4 tie goes to lower index
    irq = 16'h0024; peek();
    eq("R4 cpu_req_o", int'(cpu_req), 1);
    ack = 1; cyc();
    eq("R4 cpu_vec_o", int'(cpu_vec), 16'h1004);
    eq("R5 cpu_lvl_o", int'(cpu_lvl), 3);

    // R5 equal level blocked, higher preempts
    irq = 16'h0020; peek();
    eq("R5 equal level blocked", int'(cpu_req), 0);
    cyc();
    irq = 16'h0220; peek();
    eq("R5 preempt request", int'(cpu_req), 1);
    ack = 1; cyc();
    eq("R5 preempt vector", int'(cpu_vec), 16'h1012);
    eq("R5 preempt level", int'(cpu_lvl), 6);

    // R6 returns
    irq = '0;
    rti = 1; cyc(); eq("R6 first return", int'(cpu_lvl), 3);
    rti = 1; cyc(); eq("R6 second return", int'(cpu_lvl), 0);
    rti = 1; cyc(); eq("R6 empty return", int'(cpu_lvl), 0);

    // R7 I mask blocks CPU only
    imask = 1; irq = 16'h1200; peek();
    eq("R7 cpu blocked", int'(cpu_req), 0);
    eq("R7 cop unaffected", int'(cop_req), 1);
    cack = 1; cyc();
    eq("R11 cop vector", int'(cop_vec), 16'h1018);
    eq("R11 cop depth", int'(cop_dep), 1);

    // R12 coprocessor nesting cap
    irq = 16'h3000; peek();
    eq("R12 higher nests", int'(cop_req), 1);
    cack = 1; cyc();
    eq("R12 nested vector", int'(cop_vec), 16'h101A);
    eq("R12 depth two", int'(cop_dep), 2);
    peek();
    eq("R12 cap at two", int'(cop_req), 0);
    cdone = 1; cyc();
    irq = 16'h1000; peek();
    eq("R12 equal level blocked", int'(cop_req), 0);
    cdone = 1; cyc();
    peek();
    eq("R12 idle grants", int'(cop_req), 1);

    // R10 spurious on both sides
    imask = 0; irq = '0; peek();
    eq("R10 no request", int'(cpu_req), 0);
    ack = 1; cack = 1; cyc();
    eq("R10 cpu spurious", int'(cpu_vec), 16'h102E);
    eq("R10 cop spurious", int'(cop_vec), 16'h102E);
    eq("R10 level kept", int'(cpu_lvl), 0);

    // R8 non-maskable beats everything
    nmi = 6'b000100; xirq = 1; irq = 16'h0200;
    ack = 1; cyc();
    eq("R8 nmi vector", int'(cpu_vec), 16'h1026);
    eq("R8 nmi level", int'(cpu_lvl), 7);

    // R9 X request
    nmi = '0; peek();
    eq("R9 xirq above level 7", int'(cpu_req), 1);
    ack = 1; cyc();
    eq("R9 xirq vector", int'(cpu_vec), 16'h1020);
    xmask = 1; peek();
    eq("R9 xmask blocks", int'(cpu_req), 0);
    cyc();
    xirq = 0; xmask = 0; irq = '0;

    // R13 stack full gate
    nmi = 6'b000001;
    repeat (5) begin ack = 1; cyc(); end
    peek();
    eq("R13 full blocks nmi", int'(cpu_req), 0);
    cyc();
    nmi = '0;
    repeat (7) begin rti = 1; cyc(); end
    eq("R6 unwound", int'(cpu_lvl), 0);

    // constrained random
    for (int k = 0; k < 3000; k++) begin
      irq   = 16'($urandom);
      nmi   = ($urandom_range(0, 39) == 0) ? 6'(1 << $urandom_range(0, 5)) : '0;
      xirq  = ($urandom_range(0, 9) == 0);
      imask = ($urandom_range(0, 7) == 0);
      xmask = $urandom_range(0, 1) != 0;
      ack   = ($urandom_range(0, 3) == 0);
      rti   = ($urandom_range(0, 3) == 0);
      cack  = ($urandom_range(0, 3) == 0);
      cdone = ($urandom_range(0, 3) == 0);
      if ($urandom_range(0, 9) == 0) begin
        cfg_we = 1; cfg_idx = 4'($urandom); cfg_lvl = 3'($urandom); cfg_cop = 1'($urandom);
      end
      if ($urandom_range(0, 49) == 0) begin base_we = 1; base_d = 16'($urandom); end
      cyc();
    end
    finish_run();
  end
endmodule